// File: doc/BRIEF.md
# Two-Source Daisy-Chain Interrupt Controller

This block holds the interrupt logic for a peripheral that has two request sources, called port A and port B. It sits in a chain of devices that pass an enable signal from one to the next. The enable input comes from the device upstream, which is nearer the CPU. The enable output goes to the device downstream. A device ahead in the chain always wins over the devices behind it. Inside this device, port A wins over port B.

The port logic beside this block raises a request line for each port. This block keeps each request pending until the CPU acknowledges it. While a request is eligible, the block pulls its active-low interrupt output low. On an acknowledge it places the winning port's 8-bit vector on the data bus. The winning port then becomes under service. That state holds every lower source off, including the devices further down the chain. A return-from-interrupt opcode pair, seen on the fetch bus, ends service.

The CPU writes control words to set, for each port, the interrupt enable and the vector. The CPU bus signals follow fixed cycle rules, so no port of the block uses a valid/ready handshake and none can apply back-pressure. All bus pins are plain levels, and the block decodes the cycle type from them on every clock.

Top module: `irq_chain_ctl`

## Requirements
- R1: After reset (rst_n low), int_n is 1, ieo equals iei and data_oe is 0. No request is pending or under service, both interrupt enables are 0 and both vectors are 0x00.
- R2: A control write is a cycle with ce_n=0, iorq_n=0, m1_n=1, rd_n=1 and ctl_sel=1; port_sel picks the port (0 for A, 1 for B). A word with bit 0 clear loads the vector, with bit 0 forced to 0. A word whose low nibble is 0011 sets the enable to bit 7. Any other word has no effect.
- R3: int_n is 0 exactly when iei is 1 and some port is eligible. A port is eligible when it is pending, its enable is set, and neither that port nor a higher-priority port is under service.
- R4: ieo is 1 exactly when iei is 1, no port is under service, and no port holds a pending request with its enable set.
- R5: An acknowledge is a cycle with m1_n=0 and iorq_n=0. At the first clock of an acknowledge with iei=1, the highest-priority eligible port (A before B) stops pending and becomes under service. From that clock until the acknowledge ends, data_oe is 1 and data_o carries that port's vector. With iei=0, or with no eligible port, data_oe stays 0.
- R6: Port A can be acknowledged while port B is under service. Port B cannot raise an interrupt while port A is under service.
- R7: An opcode fetch is a cycle with m1_n=0, rd_n=0 and iorq_n=1. A fetch of 0x4D that directly follows a fetch of 0xED, with iei=1, ends service of the highest-priority port under service. Any other fetch sequence has no effect, and so has this pair when iei=0.
- R8: A request from a disabled port stays pending but neither drives int_n nor lowers ieo. It raises an interrupt once its enable is set.
- R9: A port becomes pending at any clock edge where its req_i bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read, active low |
| m1_n | input | 1 | Machine cycle one, active low |
| ctl_sel | input | 1 | 1 selects the control word path |
| port_sel | input | 1 | Port select for control writes (0 = A, 1 = B) |
| data_i | input | 8 | CPU data bus into the block |
| data_o | output | 8 | Vector driven during acknowledge |
| data_oe | output | 1 | Drive enable for data_o |
| req_i | input | 2 | Request lines from the port logic (bit 0 = A) |
| iei | input | 1 | Chain enable from the upstream device |
| ieo | output | 1 | Chain enable to the downstream device |
| int_n | output | 1 | Interrupt request, active low |

## Verification
The assertions assume three things about the CPU bus. Its signals change only between clock edges. An acknowledge and a fetch never share a cycle. A request line is never raised in the same cycle that its port is being granted, so that a grant always finds a pending flag that the same edge does not refresh. The stimulus changes every input one time unit after a rising edge. It separates every two fetches with an idle cycle, so that each fetch is a new cycle. It raises requests only in idle or control cycles.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  localparam int DW = 8;
  localparam logic [DW-1:0] RET_PREFIX = 8'hED;
  localparam logic [DW-1:0] RET_OPCODE = 8'h4D;
  localparam logic [3:0]    EN_WORD    = 4'b0011;

  typedef enum logic [1:0] {
    CYC_IDLE,
    CYC_CTRL,
    CYC_ACK,
    CYC_FETCH
  } cyc_e;

  function automatic cyc_e decode_cycle(input logic ce_n, input logic iorq_n,
                                        input logic rd_n, input logic m1_n);
    if (!m1_n && !iorq_n) return CYC_ACK;
    if (!m1_n && !rd_n) return CYC_FETCH;
    if (m1_n && !iorq_n && !ce_n && rd_n) return CYC_CTRL;
    return CYC_IDLE;
  endfunction
endpackage

// File: rtl/irq_chain_slot.sv
module irq_chain_slot
  import irq_chain_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          req,
  input  logic          grant_set,
  input  logic          svc_clr,
  output logic          pend_o,
  output logic          ie_o,
  output logic [DW-1:0] vec_o,
  output logic          insvc_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o  <= 1'b0;
      ie_o    <= 1'b0;
      vec_o   <= '0;
      insvc_o <= 1'b0;
    end else begin
      if (wr_en && !wdata[0]) vec_o <= {wdata[DW-1:1], 1'b0};
      else if (wr_en && wdata[3:0] == EN_WORD) ie_o <= wdata[DW-1];

      if (req) pend_o <= 1'b1;
      else if (grant_set) pend_o <= 1'b0;

      if (grant_set) insvc_o <= 1'b1;
      else if (svc_clr) insvc_o <= 1'b0;
    end
  end

  p_grant_needs_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    grant_set |-> pend_o);
  p_grant_sets_svc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    grant_set |=> insvc_o);
  p_end_clears_svc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_clr && !grant_set) |=> !insvc_o);
endmodule

// File: rtl/irq_chain_retdet.sv
module irq_chain_retdet
  import irq_chain_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch,
  input  logic [DW-1:0] opcode,
  output logic          ret_o
);
  logic fetch_q;
  logic saw_prefix;
  logic fetch_start;

  assign fetch_start = fetch && !fetch_q;
  assign ret_o = fetch_start && saw_prefix && (opcode == RET_OPCODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_q    <= 1'b0;
      saw_prefix <= 1'b0;
    end else begin
      fetch_q <= fetch;
      if (fetch_start) saw_prefix <= (opcode == RET_PREFIX);
    end
  end

  p_ret_consumes_prefix_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_o |=> !saw_prefix);
endmodule

// File: rtl/irq_chain_ctl.sv
module irq_chain_ctl
  import irq_chain_pkg::*;
#(
  parameter int NPORT = 2,
  localparam int SELW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_n,
  input  logic            iorq_n,
  input  logic            rd_n,
  input  logic            m1_n,
  input  logic            ctl_sel,
  input  logic [SELW-1:0] port_sel,
  input  logic [DW-1:0]   data_i,
  output logic [DW-1:0]   data_o,
  output logic            data_oe,
  input  logic [NPORT-1:0] req_i,
  input  logic            iei,
  output logic            ieo,
  output logic            int_n
);
  cyc_e cyc;
  logic ack, ack_q, ack_start, fetch, ctl_wr, ret_seen;
  logic [NPORT-1:0] pend, ie, insvc, elig, win, svc_first;
  logic [NPORT-1:0] grant_set, grant_q, svc_clr, wr_sel;
  logic [DW-1:0] vec [NPORT];

  assign cyc       = decode_cycle(ce_n, iorq_n, rd_n, m1_n);
  assign ack       = (cyc == CYC_ACK);
  assign fetch     = (cyc == CYC_FETCH);
  assign ctl_wr    = (cyc == CYC_CTRL) && ctl_sel;
  assign ack_start = ack && !ack_q;

  always_comb begin
    logic svc_seen, elig_seen;
    svc_seen  = 1'b0;
    elig_seen = 1'b0;
    for (int i = 0; i < NPORT; i++) begin
      elig[i]      = pend[i] && ie[i] && !(svc_seen || insvc[i]);
      win[i]       = elig[i] && !elig_seen;
      svc_first[i] = insvc[i] && !svc_seen;
      elig_seen    = elig_seen || elig[i];
      svc_seen     = svc_seen || insvc[i];
    end
  end

  assign grant_set = (ack_start && iei) ? win : '0;
  assign svc_clr   = (ret_seen && iei) ? svc_first : '0;

  generate
    for (genvar g = 0; g < NPORT; g++) begin : g_slot
      assign wr_sel[g] = ctl_wr && (port_sel == SELW'(g));
      irq_chain_slot u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_sel[g]),
        .wdata    (data_i),
        .req      (req_i[g]),
        .grant_set(grant_set[g]),
        .svc_clr  (svc_clr[g]),
        .pend_o   (pend[g]),
        .ie_o     (ie[g]),
        .vec_o    (vec[g]),
        .insvc_o  (insvc[g])
      );
    end
  endgenerate

  irq_chain_retdet u_ret (
    .clk   (clk),
    .rst_n (rst_n),
    .fetch (fetch),
    .opcode(data_i),
    .ret_o (ret_seen)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      grant_q <= '0;
    end else begin
      ack_q <= ack;
      if (ack_start) grant_q <= grant_set;
      else if (!ack) grant_q <= '0;
    end
  end

  always_comb begin
    data_o = '0;
    for (int i = 0; i < NPORT; i++)
      if (grant_q[i]) data_o = data_o | vec[i];
  end

  assign data_oe = ack && (|grant_q);
  assign int_n   = !(iei && (|elig));
  assign ieo     = iei && !(|(pend & ie)) && !(|insvc);

  p_int_needs_iei_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !int_n |-> iei);
  p_ieo_needs_iei_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ieo |-> iei);
  p_drive_only_in_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> ack);
  p_single_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q));
  p_single_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(svc_clr));
endmodule

// File: tb/sim_irq_chain_ctl.sv
module sim_irq_chain_ctl;
  localparam int CLK_P = 10;
  localparam logic [1:0] OI = 2'd0, OW = 2'd1, OA = 2'd2, OF = 2'd3;

  typedef struct packed {
    logic [1:0] op;
    logic       sel;
    logic [7:0] dat;
    logic [1:0] req;
    logic       iei;
    logic       x_int_n;
    logic       x_ieo;
    logic       x_oe;
    logic [7:0] x_dat;
    logic [3:0] rq;
  } step_t;

  localparam int NSTEP = 44;
  localparam step_t TBL [NSTEP] = '{
    '{OW,1'b0,8'h20,2'b00,1'b1, 1'b1,1'b1,1'b0,8'h00,4'd2}, // R2 vector A
    '{OW,1'b1,8'h40,2'b00,1'b1, 1'b1,1'b1,1'b0,8'h00,4'd2}, // R2 vector B
    '{OI,1'b0,8'h00,2'b10,1'b1, 1'b1,1'b1,1'b0,8'h00,4'd8}, // R8 R9 disabled B pending
    '{OW,1'b1,8'h87,2'b00,1'b1, 1'b1,1'b1,1'b0,8'h00,4'd2}, // R2 ignored word
    '{OW,1'b1,8'h83,2'b00,1'b1, 1'b0,1'b0,1'b0,8'h00,4'd8}, // R8 enable B
    '{OI,1'b0,8'h00,2'b00,1'b1, 1'b0,1'b0,1'b0,8'h00,4'd3}, // R3
    '{OA,1'b0,8'h00,2'b00,1'b1, 1'b1,1'b0,1'b1,8'h40,4'd5}, // R5 ack B
    '{OI,1'b0,8'h00,2'b00,1'b1, 1'b1,1'b0,1'b0,8'h00,4'd4}, // R4
    '{OI,1'b0,8'h00,2'b01,1'b1, 1'b1,1'b0,1'b0,8'h00,4'd9}, // R9 A pending
    '{OW,1'b0,8'h83,2'b00,1'b1, 1'b0,1'b0,1'b0,8'h00,4'd6}, // R6 A over B
    '{OA,1'b0,8'h00,2'b00,1'b1, 1'b1,1'b0,1'b1,8'h20,4'd6}, // R6 nested ack A
    '{OI,1'b0,8'h00,2'b00,1'b1, 1'b1,1'b0,1'b0,8'h00,4'd6},
    '{OI,1'b0,8'h00,2'b10,1'b1, 1'b1,1'b0,1'b0,8'h00,4'd6}, // R6 B blocked
    '{OF,1'b0,8'hED,2'b00,1'b1, 1'b1,1'b0,1'b0,8'h00,4'd7}, // R7
    '{OI,1'b0,8'h00,2'b00,1'b1, 1'b1,1'b0,1'b0,8'h00,4'd7},
    '{OF,1'b0,8'h4D,2'b00,1'b1, 1'b1,1'b0,1'b0,8'h00,4'd7}, // R7 ends A only
    '{OI,1'b0,8'h00,2'b00,1'b1, 1'b1,1'b0,1'b0,8'h00,4'd7},
    '{OF,1'b0,8'hED,2'b00,1'b1, 1'b1,1'b0,1'b0,8'h00,4'd7},
    '{OI,1'b0,8'h00,2'b00,1'b1, 1'b1,1'b0,1'b0,8'h00,4'd7},
    '{OF,1'b0,8'h4D,2'b00,1'b1, 1'b0,1'b0,1'b0,8'h00,4'd7}, // R7 ends B
    '{OI,1'b0,8'h00,2'b00,1'b1, 1'b0,1'b0,1'b0,8'h00,4'd3},
    '{OA,1'b0,8'h00,2'b00,1'b1, 1'b1,1'b0,1'b1,8'h40,4'd5}, // R5
    '{OI,1'b0,8'h00,2'b00,1'b1, 1'b1,1'b0,1'b0,8'h00,4'd5},
    '{OF,1'b0,8'hED,2'b00,1'b1, 1'b1,1'b0,1'b0,8'h00,4'd7},
    '{OI,1'b0,8'h00,2'b00,1'b1, 1'b1,1'b0,1'b0,8'h00,4'd7},
    '{OF,1'b0,8'h4C,2'b00,1'b1, 1'b1,1'b0,1'b0,8'h00,4'd7}, // R7 wrong opcode
    '{OI,1'b0,8'h00,2'b00,1'b1, 1'b1,1'b0,1'b0,8'h00,4'd7},
    '{OF,1'b0,8'h4D,2'b00,1'b1, 1'b1,1'b0,1'b0,8'h00,4'd7}, // R7 no prefix
    '{OI,1'b0,8'h00,2'b00,1'b1, 1'b1,1'b0,1'b0,8'h00,4'd7},
    '{OF,1'b0,8'hED,2'b00,1'b0, 1'b1,1'b0,1'b0,8'h00,4'd7},
    '{OI,1'b0,8'h00,2'b00,1'b0, 1'b1,1'b0,1'b0,8'h00,4'd7},
    '{OF,1'b0,8'h4D,2'b00,1'b0, 1'b1,1'b0,1'b0,8'h00,4'd7}, // R7 iei low
    '{OI,1'b0,8'h00,2'b00,1'b1, 1'b1,1'b0,1'b0,8'h00,4'd7}, // R7 still in service
    '{OF,1'b0,8'hED,2'b00,1'b1, 1'b1,1'b0,1'b0,8'h00,4'd7},
    '{OI,1'b0,8'h00,2'b00,1'b1, 1'b1,1'b0,1'b0,8'h00,4'd7},
    '{OF,1'b0,8'h4D,2'b00,1'b1, 1'b1,1'b1,1'b0,8'h00,4'd7}, // R7 all clear
    '{OI,1'b0,8'h00,2'b01,1'b0, 1'b1,1'b0,1'b0,8'h00,4'd3}, // R3 iei low
    '{OA,1'b0,8'h00,2'b00,1'b0, 1'b1,1'b0,1'b0,8'h00,4'd5}, // R5 no grant
    '{OI,1'b0,8'h00,2'b00,1'b1, 1'b0,1'b0,1'b0,8'h00,4'd3},
    '{OA,1'b0,8'h00,2'b00,1'b1, 1'b1,1'b0,1'b1,8'h20,4'd5},
    '{OI,1'b0,8'h00,2'b00,1'b1, 1'b1,1'b0,1'b0,8'h00,4'd5},
    '{OF,1'b0,8'hED,2'b00,1'b1, 1'b1,1'b0,1'b0,8'h00,4'd7},
    '{OI,1'b0,8'h00,2'b00,1'b1, 1'b1,1'b0,1'b0,8'h00,4'd7},
    '{OF,1'b0,8'h4D,2'b00,1'b1, 1'b1,1'b1,1'b0,8'h00,4'd7}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, m1_n = 1'b1, ctl_sel = 1'b0;
  logic [0:0] port_sel = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic [1:0] req_i = 2'b00;
  logic iei = 1'b1;
  logic [7:0] data_o;
  logic data_oe, ieo, int_n;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  irq_chain_ctl u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .iorq_n(iorq_n), .rd_n(rd_n),
    .m1_n(m1_n), .ctl_sel(ctl_sel), .port_sel(port_sel), .data_i(data_i),
    .data_o(data_o), .data_oe(data_oe), .req_i(req_i), .iei(iei),
    .ieo(ieo), .int_n(int_n)
  );

  task automatic drive(input logic [1:0] op, input logic sel, input logic [7:0] dat,
                       input logic [1:0] req, input logic ie_in);
    port_sel = sel; data_i = dat; req_i = req; iei = ie_in; ctl_sel = (op == OW);
    case (op)
      OW:      begin ce_n = 1'b0; iorq_n = 1'b0; rd_n = 1'b1; m1_n = 1'b1; end
      OA:      begin ce_n = 1'b1; iorq_n = 1'b0; rd_n = 1'b1; m1_n = 1'b0; end
      OF:      begin ce_n = 1'b1; iorq_n = 1'b1; rd_n = 1'b0; m1_n = 1'b0; end
      default: begin ce_n = 1'b1; iorq_n = 1'b1; rd_n = 1'b1; m1_n = 1'b1; end
    endcase
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic chk_outs(input string tag, input logic xi, input logic xe,
                          input logic xo, input logic [7:0] xd);
    chk({tag, " int_n"}, {7'd0, int_n}, {7'd0, xi});
    chk({tag, " ieo"}, {7'd0, ieo}, {7'd0, xe});
    chk({tag, " data_oe"}, {7'd0, data_oe}, {7'd0, xo});
    if (xo) chk({tag, " data_o"}, data_o, xd);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    drive(OI, 1'b0, 8'h00, 2'b00, 1'b1);
    repeat (3) tick();
    chk_outs("R1 reset held", 1'b1, 1'b1, 1'b0, 8'h00);
    rst_n = 1'b1;
    tick();
    chk_outs("R1 after reset", 1'b1, 1'b1, 1'b0, 8'h00);

    for (int i = 0; i < NSTEP; i++) begin
      drive(TBL[i].op, TBL[i].sel, TBL[i].dat, TBL[i].req, TBL[i].iei);
      tick();
      chk_outs($sformatf("R%0d step %0d", TBL[i].rq, i),
               TBL[i].x_int_n, TBL[i].x_ieo, TBL[i].x_oe, TBL[i].x_dat);
    end

    // R4: ieo follows iei low with no clock edge
    drive(OI, 1'b0, 8'h00, 2'b00, 1'b0);
    #1;
    chk("R4 ieo with iei low", {7'd0, ieo}, 8'h00);
    drive(OI, 1'b0, 8'h00, 2'b00, 1'b1);
    #1;
    chk("R4 ieo with iei high", {7'd0, ieo}, 8'h01);

    // R1: reset in mid activity
    drive(OI, 1'b0, 8'h00, 2'b11, 1'b1);
    tick();
    chk("R1 before reset int_n", {7'd0, int_n}, 8'h00);
    drive(OI, 1'b0, 8'h00, 2'b00, 1'b1);
    rst_n = 1'b0;
    #1;
    chk_outs("R1 async reset", 1'b1, 1'b1, 1'b0, 8'h00);
    tick();
    rst_n = 1'b1;
    tick();
    drive(OI, 1'b0, 8'h00, 2'b01, 1'b1);
    tick();
    chk_outs("R1 enable cleared", 1'b1, 1'b1, 1'b0, 8'h00);
    drive(OW, 1'b0, 8'h83, 2'b00, 1'b1);
    tick();
    chk_outs("R1 R8 enable after reset", 1'b0, 1'b0, 1'b0, 8'h00);
    drive(OA, 1'b0, 8'h00, 2'b00, 1'b1);
    tick();
    chk_outs("R1 vector cleared", 1'b1, 1'b0, 1'b1, 8'h00);
    tick();
    chk_outs("R5 held acknowledge", 1'b1, 1'b0, 1'b1, 8'h00);
    drive(OI, 1'b0, 8'h00, 2'b00, 1'b1);
    tick();
    chk_outs("R5 acknowledge ended", 1'b1, 1'b0, 1'b0, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule